// File: doc/BRIEF.md
# Transceiver Power-Control Register with Session-Valid Events

This block is one 8-bit control register of a USB transceiver's register file. The link reaches it through the transceiver's register access path. That path offers four operations, and the address chosen picks the operation. A write at 3Dh replaces the value. A write at 3Eh sets the bits that are 1 in the data. A write at 3Fh clears the bits that are 1 in the data. A read at any of these three addresses returns the current value. The immediate path decodes only the low six address bits. The extended path carries a full 8-bit address: its 00h–3Fh window folds onto the immediate addresses, and 40h–FFh is left unimplemented.

The register holds three live fields. Bit 3 enables falling-edge events and bit 2 enables rising-edge events on the B-session-valid comparator output. Bit 0 selects the role of a shared pin. When bit 0 is 0 the pin is an active-low reset input; when it is 1 the pin is an active-low power-switch output.

The comparator signal passes through a two-flop synchronizer. An enabled transition sets a one-deep pending flag. While that flag is set, the block offers a receive-command event with the alternate-interrupt flag raised. The flag stays set until the link acknowledges it.

Top module: `phy_pwr_ctl_reg`

## Requirements
- R1: After asynchronous reset the register reads 00h, `psw_sel` is 0 and `evt_valid` is 0.
- R2: A read at immediate address 3Dh, 3Eh or 3Fh returns the register. A read at any other address returns 00h.
- R3: A write at address 3Dh loads the data into the register.
- R4: A write at address 3Eh ORs the data into the register.
- R5: A write at address 3Fh clears each register bit whose data bit is 1.
- R6: Bits 7:4 and bit 1 always read 0, and writing 1 to them has no effect.
- R7: Extended accesses at 00h–3Fh act exactly like immediate accesses at the same address. Extended accesses at 40h–FFh leave the register unchanged and read 00h.
- R8: When bit 2 is 1, a low-to-high change of `sess_valid_in` raises `evt_valid`. When bit 2 is 0, it does not.
- R9: When bit 3 is 1, a high-to-low change of `sess_valid_in` raises `evt_valid`. When bit 3 is 0, it does not.
- R10: `evt_alt_int` is 1 whenever `evt_valid` is 1.
- R11: `evt_valid` stays high until a cycle with `evt_ack` high. It then drops, unless a new enabled edge arrives in that same cycle. Several edges before the acknowledge yield one event.
- R12: `evt_valid` rises on the third rising clock edge after `sess_valid_in` changes: two synchronizer stages, then the pending flag.
- R13: `psw_sel` follows bit 0 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_ext | input | 1 | 1 = extended 8-bit address, 0 = immediate 6-bit address |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_addr | input | 8 | Access address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for `acc_addr` (combinational) |
| sess_valid_in | input | 1 | Asynchronous B-session-valid comparator output |
| evt_valid | output | 1 | Receive-command event pending |
| evt_alt_int | output | 1 | Alternate-interrupt flag of the pending event |
| evt_ack | input | 1 | Link accepts the pending event |
| psw_sel | output | 1 | 1 = shared pin is power-switch output, 0 = reset input |

## Verification
The bench checks that the set and clear aliases combine with the existing value rather than replacing it. A design that decoded them as plain loads would lose bits that were already set. Writes carrying 1s in the reserved positions must read back with those bits still 0. Writes at extended addresses 7Dh and BFh look like 3Dh and 3Fh in their low bits, and they must not alias. On the event side, each edge enable is tested with the opposite edge, which must produce nothing. A rise followed by a fall before any acknowledge must collapse into one event, so a counting design would show a second event. The bench also samples one cycle before and one cycle after the expected event latency; a missing or extra synchronizer stage shows up there.

// File: rtl/phy_pwr_ctl_reg.sv
module phy_pwr_ctl_reg #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [5:0] A_LOAD = 6'h3D,
  parameter logic [DW-1:0] LIVE_MASK = 8'h0D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_ext,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  input  logic          sess_valid_in,
  output logic          evt_valid,
  output logic          evt_alt_int,
  input  logic          evt_ack,
  output logic          psw_sel
);
  localparam logic [5:0] A_SET = A_LOAD + 6'd1;
  localparam logic [5:0] A_CLR = A_LOAD + 6'd2;
  localparam int B_FALL = 3;
  localparam int B_RISE = 2;
  localparam int B_PSW  = 0;

  logic [DW-1:0] ctl;
  logic [5:0]    loc;
  logic          reachable, is_load, is_set, is_clr, hit;
  logic          s1, s2, s3, rise, fall, trig;

  assign loc       = acc_addr[5:0];
  assign reachable = !acc_ext || (acc_addr[AW-1:6] == '0);
  assign is_load   = reachable && (loc == A_LOAD);
  assign is_set    = reachable && (loc == A_SET);
  assign is_clr    = reachable && (loc == A_CLR);
  assign hit       = is_load || is_set || is_clr;
  assign acc_rdata = hit ? ctl : '0;
  assign psw_sel   = ctl[B_PSW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 ctl <= '0;
    else if (acc_wr && is_load) ctl <= acc_wdata & LIVE_MASK;
    else if (acc_wr && is_set)  ctl <= (ctl | acc_wdata) & LIVE_MASK;
    else if (acc_wr && is_clr)  ctl <= ctl & ~acc_wdata & LIVE_MASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {sess_valid_in, s1, s2};

  assign rise = s2 && !s3;
  assign fall = !s2 && s3;
  assign trig = (rise && ctl[B_RISE]) || (fall && ctl[B_FALL]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) evt_valid <= 1'b0;
    else        evt_valid <= (evt_valid && !evt_ack) || trig;

  assign evt_alt_int = evt_valid;

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rdata & ~LIVE_MASK) == '0);
  a_r7_far_ext_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_ext && acc_addr[AW-1:6] != '0) |=> $stable(ctl));
  a_r8_rise_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && ctl[B_RISE]) |=> evt_valid);
  a_r9_fall_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && ctl[B_FALL]) |=> evt_valid);
  a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ack) |=> evt_valid);
  a_r11_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ack && !trig) |=> !evt_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !trig) |=> !evt_valid);
  a_r13_psw_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    psw_sel == ctl[B_PSW]);
endmodule

// File: tb/phy_pwr_ctl_reg_tb.sv
module phy_pwr_ctl_reg_tb;
  logic clk = 0, rst_n = 0;
  logic acc_ext = 0, acc_wr = 0, sess = 0, ack = 0;
  logic [7:0] addr = 8'h3D, wdata = 0, rdata;
  logic ev, alt, psw;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  phy_pwr_ctl_reg u_dut (.clk(clk), .rst_n(rst_n), .acc_ext(acc_ext), .acc_wr(acc_wr),
    .acc_addr(addr), .acc_wdata(wdata), .acc_rdata(rdata), .sess_valid_in(sess),
    .evt_valid(ev), .evt_alt_int(alt), .evt_ack(ack), .psw_sel(psw));

  // {ext, addr, wdata, expected register}
  localparam logic [24:0] VEC [12] = '{
    {1'b0, 8'h3D, 8'hFF, 8'h0D}, {1'b0, 8'h3F, 8'h04, 8'h09},
    {1'b0, 8'h3E, 8'h02, 8'h09}, {1'b0, 8'h3E, 8'h04, 8'h0D},
    {1'b1, 8'h3F, 8'h01, 8'h0C}, {1'b1, 8'h3D, 8'h08, 8'h08},
    {1'b1, 8'h3E, 8'h05, 8'h0D}, {1'b1, 8'h7D, 8'h00, 8'h0D},
    {1'b1, 8'hBF, 8'hFF, 8'h0D}, {1'b0, 8'h3C, 8'h00, 8'h0D},
    {1'b1, 8'h3F, 8'hFF, 8'h00}, {1'b0, 8'h7D, 8'h05, 8'h05}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic e, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); acc_ext = e; addr = a; wdata = d; acc_wr = 1;
    @(negedge clk); acc_wr = 0; acc_ext = 0; addr = 8'h3D;
  endtask

  task automatic rd(input logic e, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); acc_ext = e; addr = a; #1 d = rdata;
    acc_ext = 0; addr = 8'h3D;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [7:0] v;

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20 rst_n = 1;
    rd(0, 8'h3D, v); chk("R1 reset value", v, 8'h00);
    chk("R1 psw reset", {7'b0, psw}, 8'h00);
    chk("R1 no event", {7'b0, ev}, 8'h00);

    // R3 R4 R5 R6 R7: table walk
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
      rd(0, 8'h3D, v);
      chk($sformatf("R3/R4/R5/R6/R7 vec %0d", i), v, VEC[i][7:0]);
    end

    rd(0, 8'h3E, v); chk("R2 read 3E", v, 8'h05);
    rd(0, 8'h3F, v); chk("R2 read 3F", v, 8'h05);
    rd(0, 8'h12, v); chk("R2 read other", v, 8'h00);
    rd(1, 8'h3F, v); chk("R7 ext read 3F", v, 8'h05);
    rd(1, 8'hC0, v); chk("R7 ext read unimpl", v, 8'h00);
    chk("R13 psw follows bit0", {7'b0, psw}, 8'h01);
    wr(0, 8'h3F, 8'h01);
    chk("R13 psw cleared", {7'b0, psw}, 8'h00);

    // rise enabled only
    wr(0, 8'h3D, 8'h04);
    sess = 1;
    cyc(2); chk("R12 not yet after 2 edges", {7'b0, ev}, 8'h00);
    cyc(1); chk("R8 R12 rise event", {7'b0, ev}, 8'h01);
    chk("R10 alt int", {7'b0, alt}, 8'h01);
    cyc(5); chk("R11 held without ack", {7'b0, ev}, 8'h01);
    ack = 1; cyc(1); ack = 0;
    chk("R11 ack clears", {7'b0, ev}, 8'h00);
    sess = 0; cyc(6);
    chk("R9 fall disabled", {7'b0, ev}, 8'h00);

    // fall enabled only
    wr(0, 8'h3D, 8'h08);
    sess = 1; cyc(6);
    chk("R8 rise disabled", {7'b0, ev}, 8'h00);
    sess = 0; cyc(3);
    chk("R9 fall event", {7'b0, ev}, 8'h01);
    chk("R10 alt int fall", {7'b0, alt}, 8'h01);
    ack = 1; cyc(1); ack = 0;
    chk("R11 ack clears fall", {7'b0, ev}, 8'h00);

    // both edges before ack -> one event
    wr(0, 8'h3E, 8'h04);
    sess = 1; cyc(3); sess = 0; cyc(6);
    chk("R11 merged event", {7'b0, ev}, 8'h01);
    ack = 1; cyc(1); ack = 0;
    chk("R11 single event only", {7'b0, ev}, 8'h00);
    cyc(4);
    chk("R11 stays idle", {7'b0, ev}, 8'h00);

    // reset mid-run
    wr(0, 8'h3D, 8'h0D);
    sess = 1; cyc(4);
    rst_n = 0; #3;
    chk("R1 async reset event", {7'b0, ev}, 8'h00);
    chk("R1 async reset psw", {7'b0, psw}, 8'h00);
    chk("R1 async reset value", rdata, 8'h00);
    cyc(1); rst_n = 1; sess = 0; cyc(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule